// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. When a read or write is issued, it captures the start column and the mode settings, namely the length code, the ordering bit and the single-beat-write enable. From the next cycle on it presents one column per beat and advances on each cycle in which the step enable is high.

A burst ends in one of three ways. It can run out its programmed length. It can be cut short by a stop input, which covers both a burst-stop and a precharge interrupt. It can be replaced by a fresh read or write command.

Address ordering is either sequential or interleaved. In sequential order the low bits count up and wrap inside the aligned block. In interleaved order the low bits of the start column are XORed with the beat number. A page mode walks every column of the row and never ends by itself. Command decode, the data path, CAS-latency delay and byte masking sit outside this block.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `beat_vld` and `last_beat` are 0.
- R2: A cycle with `cmd_start` high makes the next cycle carry beat 0, with `beat_vld`=1 and `col_addr` equal to the captured `cmd_col`. This happens whatever `step_en` is.
- R3: `len_code` selects the burst length: 000 is 1 beat, 001 is 2, 010 is 4, 011 is 8 and 111 is a page of 2^COL_W beats. The beat number advances only on cycles with `step_en`=1. With `step_en`=0 the address and the valid flag hold.
- R4: With `type_ilv`=0 (sequential), beat n has low log2(L) bits equal to (start low bits + n) mod L. The upper bits stay those of the start column.
- R5: With `type_ilv`=1 (interleaved), beat n has low log2(L) bits equal to the start low bits XOR n. The upper bits stay those of the start column.
- R6: In page mode (code 111, sequential) the address is (start + n) mod 2^COL_W. It wraps past the top column. The burst keeps running until it is stopped, and `last_beat` stays 0 throughout.
- R7: `last_beat` is 1 exactly on the final beat of a burst that is not page mode. A step taken on that beat clears `beat_vld` in the next cycle.
- R8: With `sbw_en`=1, a write (`cmd_wr`=1) is one beat long whatever the length code. Reads keep the programmed length.
- R9: `brst_stop` high during a burst, with no new command, clears `beat_vld` in the next cycle. This applies at any length, page mode included.
- R10: A new `cmd_start` during a burst restarts the sequence from the new column in the next cycle. It wins over a stop in the same cycle.
- R11: `cfg_err` is 1 when `len_code` is 100, 101 or 110, or when it is 111 with `type_ilv`=1. A burst started under such a setting is one beat long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the burst by one beat this cycle |
| cmd_start | input | 1 | Read or write command issued; load a new burst |
| cmd_wr | input | 1 | The command is a write |
| cmd_col | input | COL_W | Start column of the command |
| len_code | input | 3 | Programmed burst length code |
| type_ilv | input | 1 | Ordering: 0 sequential, 1 interleaved |
| sbw_en | input | 1 | Single-beat write mode |
| brst_stop | input | 1 | Burst-stop or precharge interrupt |
| col_addr | output | COL_W | Column address of the current beat |
| beat_vld | output | 1 | A beat is being presented |
| last_beat | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | Current mode setting is reserved or illegal |

## Verification
The bench sweeps every start column through each legal length in both orderings, and computes each beat's column arithmetically.

This sweep exposes three kinds of fault:
- A design that lets a carry leak out of the aligned block changes the upper column bits.
- A design that mixes up sequence and XOR order breaks the odd start columns.
- A design that treats page mode as an ordinary length raises a last flag or stops at the wrap from column 255 to 0.

Directed cases cover the remaining corners:
- Stalls on the step enable, which catch a counter that runs freely.
- A stop in mid burst, which catches a burst that overruns its end.
- A restart that coincides with a stop, which catches wrong priority.
- Single-beat writes set against reads, and reserved codes, which catch a burst that runs its programmed length when it should be cut to one beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam logic [2:0] LEN_ONE  = 3'b000;
    localparam logic [2:0] LEN_TWO  = 3'b001;
    localparam logic [2:0] LEN_FOUR = 3'b010;
    localparam logic [2:0] LEN_OCT  = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    // Width-independent description of one burst
    typedef struct packed {
        logic       page;   // runs until stopped
        order_e     order;
        logic       err;    // reserved / illegal setting seen
        logic [1:0] lg;     // log2 of beats when not page
    } bcfg_t;

    function automatic bcfg_t decode_mode(input logic [2:0] code,
                                          input logic       ilv,
                                          input logic       wr,
                                          input logic       sbw);
        bcfg_t c;
        c.page  = 1'b0;
        c.order = ilv ? ORD_ILV : ORD_SEQ;
        c.err   = 1'b0;
        c.lg    = 2'd0;
        case (code)
            LEN_ONE:  c.lg = 2'd0;
            LEN_TWO:  c.lg = 2'd1;
            LEN_FOUR: c.lg = 2'd2;
            LEN_OCT:  c.lg = 2'd3;
            LEN_PAGE: begin
                if (ilv) c.err  = 1'b1;
                else     c.page = 1'b1;
            end
            default:  c.err = 1'b1;
        endcase
        if (wr && sbw) begin
            c.page = 1'b0;
            c.lg   = 2'd0;
        end
        return c;
    endfunction

endpackage

// File: rtl/bcg_decode.sv
module bcg_decode
    import bcg_pkg::*;
(
    input  logic [2:0] len_code,
    input  logic       type_ilv,
    input  logic       cmd_wr,
    input  logic       sbw_en,
    output bcfg_t      cfg,
    output logic       cfg_err
);
    bcfg_t mode_only;

    always_comb begin
        cfg       = decode_mode(len_code, type_ilv, cmd_wr, sbw_en);
        mode_only = decode_mode(len_code, type_ilv, 1'b0, 1'b0);
        cfg_err   = mode_only.err;
    end
endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             start,
    input  logic             stop,
    input  bcfg_t            cfg_in,
    input  logic [COL_W-1:0] start_col,
    output logic             vld,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] col_q,
    output logic [COL_W-1:0] mask,
    output bcfg_t            cfg_q,
    output logic             last
);
    localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

    logic             vld_q;
    logic [COL_W-1:0] beat_q;

    always_comb begin
        mask = cfg_q.page ? ONES : ~(ONES << cfg_q.lg);
        last = vld_q && !cfg_q.page && (beat_q == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            beat_q <= '0;
            col_q  <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            vld_q  <= 1'b1;
            beat_q <= '0;
            col_q  <= start_col;
            cfg_q  <= cfg_in;
        end else if (vld_q) begin
            if (stop)
                vld_q <= 1'b0;
            else if (step_en) begin
                if (last) vld_q  <= 1'b0;
                else      beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign vld  = vld_q;
    assign beat = beat_q;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (vld_q && beat_q == '0));
    // R9
    stop_end_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !vld_q);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !step_en && !stop && !start) |=> (vld_q && $stable(beat_q)));
    // R7
    final_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (last && step_en && !stop && !start) |=> !vld_q);
    // R6
    page_run_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && cfg_q.page && step_en && !stop && !start) |=> vld_q);
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  bcfg_t            cfg_q,
    input  logic [COL_W-1:0] col_q,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] col_addr
);
    logic [COL_W-1:0] sum;

    // Carries out of the masked field are discarded bit by bit below
    assign sum = col_q + beat;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask[i])
                col_addr[i] = col_q[i];
            else if (cfg_q.order == ORD_ILV)
                col_addr[i] = col_q[i] ^ beat[i];
            else
                col_addr[i] = sum[i];
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             cmd_start,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       len_code,
    input  logic             type_ilv,
    input  logic             sbw_en,
    input  logic             brst_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             beat_vld,
    output logic             last_beat,
    output logic             cfg_err
);
    bcfg_t            cfg_new;
    bcfg_t            cfg_q;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] mask;

    bcg_decode u_dec (
        .len_code (len_code),
        .type_ilv (type_ilv),
        .cmd_wr   (cmd_wr),
        .sbw_en   (sbw_en),
        .cfg      (cfg_new),
        .cfg_err  (cfg_err)
    );

    bcg_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .start     (cmd_start),
        .stop      (brst_stop),
        .cfg_in    (cfg_new),
        .start_col (cmd_col),
        .vld       (beat_vld),
        .beat      (beat),
        .col_q     (col_q),
        .mask      (mask),
        .cfg_q     (cfg_q),
        .last      (last_beat)
    );

    bcg_addr #(.COL_W(COL_W)) u_addr (
        .cfg_q    (cfg_q),
        .col_q    (col_q),
        .beat     (beat),
        .mask     (mask),
        .col_addr (col_addr)
    );

    // R4
    block_keep_chk: assert property (@(posedge clk) disable iff (rst)
        beat_vld |-> (((col_addr ^ col_q) & ~mask) == '0));
    // R8
    sbw_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && cmd_wr && sbw_en) |=> last_beat);
    // R11
    err_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && cfg_err) |=> last_beat);
endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step_en = 1'b0, cmd_start = 1'b0, cmd_wr = 1'b0;
    logic [CW-1:0] cmd_col = '0;
    logic [2:0]    len_code = 3'b000;
    logic          type_ilv = 1'b0, sbw_en = 1'b0, brst_stop = 1'b0;
    logic [CW-1:0] col_addr;
    logic          beat_vld, last_beat, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(CW)) u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .cmd_start(cmd_start),
        .cmd_wr(cmd_wr), .cmd_col(cmd_col), .len_code(len_code),
        .type_ilv(type_ilv), .sbw_en(sbw_en), .brst_stop(brst_stop),
        .col_addr(col_addr), .beat_vld(beat_vld), .last_beat(last_beat),
        .cfg_err(cfg_err)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int col, input int k, input int len, input int ilv);
        int m;
        if (len == 0) return (col + k) % 256;
        m = len - 1;
        if (ilv != 0) return (col & ~m) | ((col & m) ^ k);
        return (col & ~m) | (((col & m) + k) % len);
    endfunction

    task automatic launch(input int col, input bit wr, input int code, input bit ilv);
        @(negedge clk);
        cmd_start = 1'b1; cmd_col = CW'(col); cmd_wr = wr;
        len_code = 3'(code); type_ilv = ilv; step_en = 1'b1; brst_stop = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    // len: expected beats, 0 means page mode (run nb beats then stop)
    task automatic run_burst(input int col, input bit wr, input int code,
                             input bit ilv, input int len, input int nb);
        int beats;
        string tag;
        tag = ilv ? "R5" : (len == 0 ? "R6" : "R4");
        launch(col, wr, code, ilv);
        beats = (len == 0) ? nb : len;
        for (int k = 0; k < beats; k++) begin
            if (k > 0) @(negedge clk);
            chk("R3 valid", int'(beat_vld), 1);
            chk(k == 0 ? "R2" : tag, int'(col_addr), exp_addr(col, k, len, ilv));
            chk("R7 last", int'(last_beat), (len != 0 && k == len - 1) ? 1 : 0);
        end
        if (len != 0) begin
            @(negedge clk);
            chk("R7 end", int'(beat_vld), 0);
        end else begin
            brst_stop = 1'b1;
            @(negedge clk);
            brst_stop = 1'b0;
            chk("R9 page stop", int'(beat_vld), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 vld in reset", int'(beat_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 vld", int'(beat_vld), 0);
        chk("R1 last", int'(last_beat), 0);

        // Sweep: every start column, lengths 1..8, both orders
        for (int code = 0; code < 4; code++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int col = 0; col < 256; col++)
                    run_burst(col, 1'b0, code, ilv[0], 1 << code, 0);

        // R6 page mode with wrap past the top column
        run_burst(0,   1'b0, 7, 1'b0, 0, 300);
        run_burst(77,  1'b0, 7, 1'b0, 0, 260);
        run_burst(255, 1'b0, 7, 1'b0, 0, 5);

        // R11 reserved codes and page+interleave
        for (int code = 4; code < 7; code++) begin
            launch(9, 1'b0, code, 1'b0);
            chk("R11 err", int'(cfg_err), 1);
            chk("R11 one beat", int'(last_beat), 1);
            chk("R11 addr", int'(col_addr), 9);
            @(negedge clk);
            chk("R11 end", int'(beat_vld), 0);
        end
        launch(40, 1'b0, 7, 1'b1);
        chk("R11 page ilv err", int'(cfg_err), 1);
        chk("R11 page ilv one", int'(last_beat), 1);
        @(negedge clk);
        chk("R11 page ilv end", int'(beat_vld), 0);
        len_code = 3'b011; type_ilv = 1'b1;
        #1;
        chk("R11 legal no err", int'(cfg_err), 0);

        // R8 single-beat write against read
        sbw_en = 1'b1;
        run_burst(21, 1'b1, 3, 1'b0, 1, 0);
        run_burst(21, 1'b0, 3, 1'b0, 8, 0);
        run_burst(100, 1'b1, 7, 1'b0, 1, 0);
        sbw_en = 1'b0;
        run_burst(21, 1'b1, 2, 1'b1, 4, 0);

        // R3 stall holds the address
        launch(3, 1'b0, 3, 1'b0);
        step_en = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R3 hold addr", int'(col_addr), 3);
            chk("R3 hold vld", int'(beat_vld), 1);
        end
        step_en = 1'b1;
        @(negedge clk);
        chk("R3 resume", int'(col_addr), 4);
        repeat (7) @(negedge clk);

        // R9 stop in mid burst
        launch(50, 1'b0, 2, 1'b0);
        @(negedge clk);
        chk("R9 beat1", int'(col_addr), 51);
        brst_stop = 1'b1;
        @(negedge clk);
        brst_stop = 1'b0;
        chk("R9 stopped", int'(beat_vld), 0);
        @(negedge clk);
        chk("R9 stays idle", int'(beat_vld), 0);

        // R10 restart wins over a simultaneous stop
        launch(10, 1'b0, 3, 1'b0);
        @(negedge clk);
        cmd_start = 1'b1; cmd_col = 8'd200; brst_stop = 1'b1;
        len_code = 3'b010; type_ilv = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; brst_stop = 1'b0;
        chk("R10 vld", int'(beat_vld), 1);
        chk("R10 addr", int'(col_addr), 200);
        @(negedge clk);
        chk("R10 next", int'(col_addr), 201);
        @(negedge clk);
        chk("R10 next2", int'(col_addr), 202);
        @(negedge clk);
        chk("R10 last", int'(last_beat), 1);
        @(negedge clk);
        chk("R10 end", int'(beat_vld), 0);

        summary();
        $finish;
    end
endmodule